// File: doc/BRIEF.md
# Serial Memory Command Engine

This block is the slave-side protocol engine of a byte-wide nonvolatile memory that is reached over a four-wire serial bus. It samples the serial input on each rising serial-clock edge and shifts read data out on each falling edge. It decodes a one-byte command and gathers a 16-bit address and data bytes. Reads stream out of a memory array with automatic address increment. Writes collect into a 64-byte page buffer and are committed to the array only when chip select rises on a legal clock count.

All pins are sampled in a single fast system clock domain. The engine drives a synchronous read/write port of an external array with one cycle of read latency. It also exchanges one-cycle pulses with a separate status/protection unit. That unit supplies the status byte, a busy flag and a write-permission flag. It receives the write-enable set/clear pulses and the status-write request. A pause input suspends a transfer without deselecting the device.

Top module: `spiMemEngine`

## Requirements
- R1: Commands are the first 8 bits after select, MSB first: 06h latch-enable, 04h latch-disable, 05h status read, 01h status write, 03h array read, 02h array write. Any other code leaves `soEn` low and causes no pulse and no array write until `csN` goes high.
- R2: An array read takes a 16-bit address, MSB first, whose top bit is ignored. The byte at that address appears MSB first on `soData`, one bit per falling `sck`, starting at the falling edge after the 24th rising edge. Before that, `soEn` is low.
- R3: While `csN` stays low, a read continues with the next address after every 8 bits, and address 7FFFh is followed by 0000h.
- R4: An array read or array write issued while `devBusy` is high, or while a page commit runs, is refused: `soEn` stays low and nothing is written.
- R5: A status read shifts out `statusByte`, MSB first, and repeats it every 8 bits. It is served even while `devBusy` is high.
- R6: `welSet` (after 06h) or `welClr` (after 04h) pulses for one cycle only when `csN` rises after exactly 8 rising clock edges. At most one of the four launch outputs is active in any cycle.
- R7: `statWrReq` pulses, with `statWrData` holding the received byte, only when a status write ends after exactly 16 clocks while `wrPermit` is high and the engine is not busy.
- R8: An array write is committed only when `csN` rises after 24 + 8*m clocks with m >= 1. The commit then writes every buffered byte to the array at the page's upper address bits and its buffer index.
- R9: During a write, only the low 6 address bits advance after each data byte. Past 64 bytes they wrap, and the later byte replaces the earlier one.
- R10: An array write or status write that ends while `wrPermit` is low changes nothing.
- R11: The pause state follows `holdN` only while `sck` is low: it starts or ends at once if `sck` is low, otherwise at the next low level. While paused, `soEn` is low and `sck` and `si` have no effect on the transfer.
- R12: While `csN` is high, `soEn` is low and the bit count restarts at the next select.
- R13: The clock counter saturates at its maximum (1023 by default). A write long enough to reach that maximum is never committed, even when its total length would otherwise be a legal count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| holdN | input | 1 | Pause request, active low |
| soData | output | 1 | Serial data out value |
| soEn | output | 1 | Serial data out drive enable (low = high impedance) |
| memAddr | output | AW | Array address for reads and commit writes |
| memWe | output | 1 | Array write strobe |
| memWdata | output | 8 | Array write data |
| memRdData | input | 8 | Array read data, one cycle after `memAddr` |
| statusByte | input | 8 | Status byte from the status/protection unit |
| devBusy | input | 1 | An internal write is in progress |
| wrPermit | input | 1 | Status/protection unit allows the pending write |
| welSet | output | 1 | Pulse: set the write-enable latch |
| welClr | output | 1 | Pulse: clear the write-enable latch |
| statWrReq | output | 1 | Pulse: start a status-register write |
| statWrData | output | 8 | Byte received by a status write |
| pageBusy | output | 1 | Page buffer is being committed to the array |

## Verification
The bench targets the clock-count edges of the launch rules: 8 versus 9 clocks, 16 versus 17, a write cut three bits past a byte, and a write long enough to saturate the counter. A design that commits on any chip-select rise would corrupt the array after a partial byte. A counter that wraps instead of saturating would commit an overlong write. Page wrap is checked with a 66-byte burst that starts two bytes before the page end; an engine that carries into the upper bits would write into the next page. Pause is entered both with the clock low and with it high. A design that ignores the clock-level rule would either drop a bit or tri-state one edge too early. Because the bench's reference memory is rebuilt independently, a misplaced byte appears as a readback mismatch.

// File: rtl/spiEngPkg.sv
package spiEngPkg;

  typedef enum logic [2:0] {
    OP_CMD,
    OP_READ,
    OP_RDSR,
    OP_WRITE,
    OP_WRSR,
    OP_WREN,
    OP_WRDI,
    OP_SKIP
  } opState_t;

  localparam logic [7:0] CODE_WREN = 8'h06;
  localparam logic [7:0] CODE_WRDI = 8'h04;
  localparam logic [7:0] CODE_RDSR = 8'h05;
  localparam logic [7:0] CODE_WRSR = 8'h01;
  localparam logic [7:0] CODE_READ = 8'h03;
  localparam logic [7:0] CODE_WRITE = 8'h02;

  // strobes from control to datapath, all valid for one clk
  typedef struct packed {
    logic capBit;     // a data bit is sampled this cycle
    logic addrShift;  // sampled bit belongs to the address
    logic dataByte;   // last bit of a write data byte
    logic statByte;   // last bit of the status-write byte
    logic openPage;   // accepted array write: empty the page buffer
    logic loadMem;    // falling edge: load next array byte
    logic loadStat;   // falling edge: load status byte
    logic shiftOut;   // falling edge: advance output shifter
    logic outClear;   // deselected: stop driving
    logic launchPage; // start committing the page buffer
  } strobe_t;

endpackage

// File: rtl/spiEngCtrl.sv
module spiEngCtrl
  import spiEngPkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csN,
  input  logic    sck,
  input  logic    si,
  input  logic    holdN,
  input  logic    busy,
  input  logic    wrPermit,
  output strobe_t stb,
  output logic    held,
  output logic    welSet,
  output logic    welClr,
  output logic    statWrReq
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] bitCnt;
  logic [6:0] opShift;
  logic sckQ, csQ;
  opState_t opState, opNext;

  logic active, sckRise, sckFall, csRise, cntSat, byteEdge;

  assign active   = !csN && !held;
  assign sckRise  = active && sck && !sckQ;
  assign sckFall  = active && !sck && sckQ;
  assign csRise   = csN && !csQ;
  assign cntSat   = (bitCnt == CNT_MAX);
  assign byteEdge = (bitCnt[2:0] == 3'd0);

  // command decode on the eighth sampled bit
  always_comb begin
    case ({opShift, si})
      CODE_WREN:  opNext = OP_WREN;
      CODE_WRDI:  opNext = OP_WRDI;
      CODE_RDSR:  opNext = OP_RDSR;
      CODE_WRSR:  opNext = OP_WRSR;
      CODE_READ:  opNext = busy ? OP_SKIP : OP_READ;
      CODE_WRITE: opNext = busy ? OP_SKIP : OP_WRITE;
      default:    opNext = OP_SKIP;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckQ      <= 1'b0;
      csQ       <= 1'b1;
      held      <= 1'b0;
      bitCnt    <= '0;
      opShift   <= '0;
      opState   <= OP_CMD;
      welSet    <= 1'b0;
      welClr    <= 1'b0;
      statWrReq <= 1'b0;
    end else begin
      sckQ <= sck;
      csQ  <= csN;
      // pause follows holdN only while the serial clock is low
      if (csN) held <= 1'b0;
      else if (!sck) held <= !holdN;

      if (csN) begin
        bitCnt  <= '0;
        opShift <= '0;
        opState <= OP_CMD;
      end else if (sckRise) begin
        if (!cntSat) bitCnt <= bitCnt + 1'b1;
        if (bitCnt < 7) opShift <= {opShift[5:0], si};
        if (bitCnt == 7) opState <= opNext;
      end

      welSet    <= csRise && opState == OP_WREN && bitCnt == 8;
      welClr    <= csRise && opState == OP_WRDI && bitCnt == 8;
      statWrReq <= csRise && opState == OP_WRSR && bitCnt == 16 && wrPermit && !busy;
    end
  end

  always_comb begin
    stb            = '0;
    stb.capBit     = sckRise;
    stb.addrShift  = sckRise && (opState == OP_READ || opState == OP_WRITE)
                     && bitCnt >= 8 && bitCnt < 24;
    stb.dataByte   = sckRise && opState == OP_WRITE && bitCnt >= 24
                     && bitCnt[2:0] == 3'd7 && !cntSat;
    stb.statByte   = sckRise && opState == OP_WRSR && bitCnt == 15;
    stb.openPage   = sckRise && bitCnt == 7 && opNext == OP_WRITE;
    stb.loadMem    = sckFall && opState == OP_READ && bitCnt >= 24 && byteEdge;
    stb.loadStat   = sckFall && opState == OP_RDSR && bitCnt >= 8 && byteEdge;
    stb.shiftOut   = sckFall && !stb.loadMem && !stb.loadStat;
    stb.outClear   = csN;
    stb.launchPage = csRise && opState == OP_WRITE && bitCnt >= 32 && byteEdge
                     && !cntSat && wrPermit && !busy;
  end

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    held && !csN |=> $stable(bitCnt)); // R11
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({welSet, welClr, statWrReq, stb.launchPage})); // R6
  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt == CNT_MAX |=> bitCnt == CNT_MAX || bitCnt == '0); // R13

endmodule

// File: rtl/spiEngData.sv
module spiEngData
  import spiEngPkg::*;
#(
  parameter int AW     = 15,
  parameter int PAGE_W = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic          si,
  input  logic          held,
  input  logic [7:0]    memRdData,
  input  logic [7:0]    statusByte,
  output logic          soData,
  output logic          soEn,
  output logic [AW-1:0] memAddr,
  output logic          memWe,
  output logic [7:0]    memWdata,
  output logic [7:0]    statWrData,
  output logic          pageBusy
);

  localparam int PAGE  = 1 << PAGE_W;
  localparam int UPPER = AW - PAGE_W;

  logic [6:0]        inShift;
  logic [AW-1:0]     addrReg;
  logic [7:0]        outShift;
  logic              outOn;
  logic [7:0]        pageMem [PAGE];
  logic [PAGE-1:0]   pageVld;
  logic              walkOn;
  logic [PAGE_W-1:0] walkIdx;
  logic [UPPER-1:0]  walkBase;
  logic [7:0]        rxByte;

  assign rxByte = {inShift, si};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inShift    <= '0;
      addrReg    <= '0;
      statWrData <= '0;
    end else begin
      if (stb.capBit) inShift <= {inShift[5:0], si};
      if (stb.addrShift) addrReg <= {addrReg[AW-2:0], si};
      else if (stb.dataByte) addrReg[PAGE_W-1:0] <= addrReg[PAGE_W-1:0] + 1'b1;
      else if (stb.loadMem) addrReg <= addrReg + 1'b1;
      if (stb.statByte) statWrData <= rxByte;
    end
  end

  // page buffer: contents need no reset, the valid flags do
  always_ff @(posedge clk) begin
    if (stb.dataByte) pageMem[addrReg[PAGE_W-1:0]] <= rxByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pageVld <= '0;
    else if (stb.openPage) pageVld <= '0;
    else if (stb.dataByte) pageVld[addrReg[PAGE_W-1:0]] <= 1'b1;
  end

  // commit walker: one buffer slot per cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      walkOn   <= 1'b0;
      walkIdx  <= '0;
      walkBase <= '0;
    end else if (stb.launchPage) begin
      walkOn   <= 1'b1;
      walkIdx  <= '0;
      walkBase <= addrReg[AW-1:PAGE_W];
    end else if (walkOn) begin
      walkIdx <= walkIdx + 1'b1;
      if (walkIdx == {PAGE_W{1'b1}}) walkOn <= 1'b0;
    end
  end

  assign memWe    = walkOn && pageVld[walkIdx];
  assign memWdata = pageMem[walkIdx];
  assign memAddr  = walkOn ? {walkBase, walkIdx} : addrReg;
  assign pageBusy = walkOn;

  // output shifter, updated on falling serial clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outShift <= '0;
      outOn    <= 1'b0;
    end else if (stb.outClear) begin
      outOn <= 1'b0;
    end else if (stb.loadMem) begin
      outShift <= memRdData;
      outOn    <= 1'b1;
    end else if (stb.loadStat) begin
      outShift <= statusByte;
      outOn    <= 1'b1;
    end else if (stb.shiftOut) begin
      outShift <= {outShift[6:0], 1'b0};
    end
  end

  assign soData = outShift[7];
  assign soEn   = outOn && !held;

  AST_SO_OFF_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    stb.outClear && $past(stb.outClear) |-> !soEn); // R12
  AST_LAUNCH_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    stb.launchPage |-> !walkOn); // R8

endmodule

// File: rtl/spiMemEngine.sv
module spiMemEngine
  import spiEngPkg::*;
#(
  parameter int AW     = 15,
  parameter int PAGE_W = 6,
  parameter int CNT_W  = 10
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          csN,
  input  logic          sck,
  input  logic          si,
  input  logic          holdN,
  output logic          soData,
  output logic          soEn,
  output logic [AW-1:0] memAddr,
  output logic          memWe,
  output logic [7:0]    memWdata,
  input  logic [7:0]    memRdData,
  input  logic [7:0]    statusByte,
  input  logic          devBusy,
  input  logic          wrPermit,
  output logic          welSet,
  output logic          welClr,
  output logic          statWrReq,
  output logic [7:0]    statWrData,
  output logic          pageBusy
);

  strobe_t stb;
  logic    held;
  logic    busyAll;

  assign busyAll = devBusy || pageBusy;

  spiEngCtrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si), .holdN(holdN),
    .busy(busyAll), .wrPermit(wrPermit), .stb(stb), .held(held),
    .welSet(welSet), .welClr(welClr), .statWrReq(statWrReq)
  );

  spiEngData #(.AW(AW), .PAGE_W(PAGE_W)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .si(si), .held(held),
    .memRdData(memRdData), .statusByte(statusByte),
    .soData(soData), .soEn(soEn), .memAddr(memAddr), .memWe(memWe),
    .memWdata(memWdata), .statWrData(statWrData), .pageBusy(pageBusy)
  );

endmodule

// File: tb/spiMemEngine_bench.sv
module spiMemEngine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 15;

  logic clk = 0, rstN = 0, csN = 1, sck = 0, si = 0, holdN = 1;
  logic soData, soEn, memWe, welSet, welClr, statWrReq, pageBusy;
  logic [AW-1:0] memAddr;
  logic [7:0] memWdata, statWrData, statusByte = 8'h00;
  logic [7:0] memRdData = 8'hFF;
  logic devBusy = 0, wrPermit = 1;

  int nChecks = 0, nFail = 0, nWelSet = 0, nWelClr = 0, nStatReq = 0;
  int csHighCnt = 0;
  bit finished = 0;
  logic [7:0] arrayMem [int];
  logic [7:0] refMem [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  spiMemEngine u_spiMemEngine (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si), .holdN(holdN),
    .soData(soData), .soEn(soEn), .memAddr(memAddr), .memWe(memWe),
    .memWdata(memWdata), .memRdData(memRdData), .statusByte(statusByte),
    .devBusy(devBusy), .wrPermit(wrPermit), .welSet(welSet), .welClr(welClr),
    .statWrReq(statWrReq), .statWrData(statWrData), .pageBusy(pageBusy)
  );

  // synchronous array model with one cycle read latency
  always @(posedge clk) begin
    if (memWe) arrayMem[int'(memAddr)] = memWdata;
    memRdData <= arrayMem.exists(int'(memAddr)) ? arrayMem[int'(memAddr)] : 8'hFF;
    if (welSet) nWelSet++;
    if (welClr) nWelClr++;
    if (statWrReq) nStatReq++;
    csHighCnt <= csN ? csHighCnt + 1 : 0;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison: deselected device never drives
  always @(negedge clk) begin
    if (rstN && csHighCnt >= 2) check("R12 deselected soEn", {31'd0, soEn}, 32'd0);
  end

  function automatic logic [7:0] refByte(input int a);
    return refMem.exists(a) ? refMem[a] : 8'hFF;
  endfunction

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitX(input logic b, output logic r, output logic e);
    si = b; waitClk(4);
    sck = 1; waitClk(2);
    r = soData; e = soEn; waitClk(2);
    sck = 0;
  endtask

  task automatic xByte(input logic [7:0] tx, output logic [7:0] rx, output logic allEn);
    logic r, e;
    allEn = 1;
    for (int i = 7; i >= 0; i--) begin
      bitX(tx[i], r, e);
      rx[i] = r;
      allEn &= e;
    end
  endtask

  task automatic csDown(); csN = 0; waitClk(4); endtask
  task automatic csUp(); waitClk(4); csN = 1; waitClk(4); endtask

  task automatic sendByte(input logic [7:0] tx);
    logic [7:0] rx; logic en;
    xByte(tx, rx, en);
  endtask

  task automatic doRead(input logic [15:0] a, input int n, input string tag);
    logic [7:0] rx; logic en;
    csDown();
    sendByte(8'h03); sendByte(a[15:8]); sendByte(a[7:0]);
    for (int k = 0; k < n; k++) begin
      xByte(8'h00, rx, en);
      check(tag, {23'd0, en, rx}, {23'd0, 1'b1, refByte((int'(a) + k) & 32'h7FFF)});
    end
    csUp();
  endtask

  task automatic doWrite(input logic [15:0] a, input int n, input logic [7:0] seed,
                         input int extraBits);
    logic r, e;
    csDown();
    sendByte(8'h02); sendByte(a[15:8]); sendByte(a[7:0]);
    for (int k = 0; k < n; k++) sendByte(seed + 8'(k * 7));
    for (int k = 0; k < extraBits; k++) bitX(1'b1, r, e);
    csUp();
    waitClk(80);
  endtask

  task automatic refPage(input logic [15:0] a, input int n, input logic [7:0] seed);
    for (int k = 0; k < n; k++)
      refMem[(int'(a) & 32'h7FC0) | ((int'(a) + k) & 32'h3F)] = seed + 8'(k * 7);
  endtask

  initial begin
    logic [7:0] rx, rb; logic en, r, e;
    int w0, c0, s0;
    for (int i = 0; i < 8; i++) begin
      arrayMem[32'h0100 + i] = 8'h30 + 8'(i * 5);
      refMem[32'h0100 + i]   = 8'h30 + 8'(i * 5);
    end
    arrayMem[32'h7FFF] = 8'hC3; refMem[32'h7FFF] = 8'hC3;
    arrayMem[32'h0000] = 8'h5A; refMem[32'h0000] = 8'h5A;
    waitClk(3);
    check("R12 reset soEn", {31'd0, soEn}, 0);
    check("R6 reset pulses", {29'd0, welSet, welClr, statWrReq}, 0);
    rstN = 1; waitClk(3);

    // R2 / R3 reads
    doRead(16'h0100, 4, "R2 R3 read sequence");
    doRead(16'h8102, 2, "R2 top address bit ignored");
    doRead(16'h7FFF, 2, "R3 rollover");

    // R1 unknown command
    w0 = nWelSet; s0 = nStatReq;
    csDown(); sendByte(8'hA5);
    for (int k = 0; k < 3; k++) begin
      xByte(8'h06, rx, en);
      check("R1 unknown code soEn", {31'd0, en}, 0);
    end
    csUp();
    check("R1 no pulse", nWelSet + nStatReq, w0 + s0);

    // R4 busy refuses read, R5 status while busy
    devBusy = 1;
    csDown(); sendByte(8'h03); sendByte(8'h01); sendByte(8'h00);
    xByte(8'h00, rx, en);
    check("R4 read refused while busy", {31'd0, en}, 0);
    csUp();
    statusByte = 8'hA3;
    csDown(); sendByte(8'h05);
    for (int k = 0; k < 2; k++) begin
      xByte(8'h00, rx, en);
      check("R5 status repeat", {23'd0, en, rx}, {23'd0, 1'b1, 8'hA3});
    end
    csUp();
    doWrite(16'h0104, 1, 8'h99, 0);
    devBusy = 0;
    doRead(16'h0104, 1, "R4 write refused while busy");

    // R6 latch enable / disable counts
    w0 = nWelSet; c0 = nWelClr;
    csDown(); sendByte(8'h06); csUp();
    check("R6 enable after 8 clocks", nWelSet, w0 + 1);
    csDown(); sendByte(8'h06); bitX(1'b0, r, e); csUp();
    check("R6 enable after 9 clocks ignored", nWelSet, w0 + 1);
    csDown(); sendByte(8'h04); csUp();
    check("R6 disable after 8 clocks", nWelClr, c0 + 1);

    // R7 status write
    s0 = nStatReq;
    csDown(); sendByte(8'h01); sendByte(8'h8C); csUp();
    check("R7 status write request", nStatReq, s0 + 1);
    check("R7 status write data", {24'd0, statWrData}, {24'd0, 8'h8C});
    csDown(); sendByte(8'h01); sendByte(8'h44); bitX(1'b0, r, e); csUp();
    check("R7 17 clocks cancelled", nStatReq, s0 + 1);
    wrPermit = 0;
    csDown(); sendByte(8'h01); sendByte(8'h44); csUp();
    check("R10 status write without permission", nStatReq, s0 + 1);

    // R8 writes
    doWrite(16'h0234, 3, 8'h11, 0);
    doRead(16'h0234, 3, "R10 write without permission");
    wrPermit = 1;
    doWrite(16'h0234, 3, 8'h11, 0); refPage(16'h0234, 3, 8'h11);
    doRead(16'h0233, 5, "R8 three-byte write");
    doWrite(16'h0300, 1, 8'h22, 3);
    doRead(16'h0300, 1, "R8 partial byte cancels");

    // R9 page wrap
    doWrite(16'h0A3E, 66, 8'h05, 0); refPage(16'h0A3E, 66, 8'h05);
    doRead(16'h0A00, 64, "R9 page wrap");
    doRead(16'h0A40, 1, "R9 next page untouched");

    // R11 pause
    csDown(); sendByte(8'h03); sendByte(8'h01); sendByte(8'h00);
    xByte(8'h00, rx, en);
    check("R11 byte before pause", {23'd0, en, rx}, {23'd0, 1'b1, refByte(32'h0100)});
    holdN = 0; waitClk(3);
    check("R11 pause with clock low", {31'd0, soEn}, 0);
    for (int k = 0; k < 5; k++) begin si = ~si; sck = 1; waitClk(2); sck = 0; waitClk(2); end
    holdN = 1; waitClk(3);
    check("R11 release", {31'd0, soEn}, 1);
    si = 0; waitClk(4); sck = 1; waitClk(2);
    rb[7] = soData; holdN = 0; waitClk(2);
    check("R11 pause waits for clock low", {31'd0, soEn}, 1);
    sck = 0; waitClk(3);
    check("R11 pause at clock low", {31'd0, soEn}, 0);
    for (int k = 0; k < 3; k++) begin si = ~si; sck = 1; waitClk(2); sck = 0; waitClk(2); end
    holdN = 1; waitClk(3);
    for (int i = 6; i >= 0; i--) begin bitX(1'b0, r, e); rb[i] = r; end
    check("R11 byte across pauses", {24'd0, rb}, {24'd0, refByte(32'h0101)});
    xByte(8'h00, rx, en);
    check("R11 byte after pauses", {23'd0, en, rx}, {23'd0, 1'b1, refByte(32'h0102)});
    csUp();

    // R13 saturation
    doWrite(16'h0500, 125, 8'h40, 0);
    doRead(16'h0500, 2, "R13 saturated write not committed");
    doWrite(16'h0500, 124, 8'h40, 0); refPage(16'h0500, 124, 8'h40);
    doRead(16'h0500, 4, "R13 longest legal write");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end
endmodule